// File: doc/BRIEF.md
# UART Command Register Controller

This block is the write-only command register of one UART channel. Software writes a command byte. The byte is split into three fields, and each field is decoded on its own, so one write can carry a miscellaneous action, a transmitter request and a receiver request together. The resulting actions drive three kinds of output:

- enable levels for the transmit and receive paths;
- single-cycle pulses to the mode-pointer logic, the receive FIFO and the break generator;
- clears to the status flags the command set is allowed to touch.

The block also holds those status flags. The serial datapath raises them through `flag_set`, and the flag state is visible on `flags`, so the effect of every command can be observed at the ports. The register contents are not stored. Every command acts once, and its effects appear in the clock cycle after the write strobe.

Command byte layout:

| Bits | Field | Role |
|------|-------|------|
| 7 | reserved | no effect |
| 6:4 | miscellaneous | one action |
| 3:2 | transmitter | enable request |
| 1:0 | receiver | enable request |

Flag vector positions:

| Bit | Flag |
|-----|------|
| 0 | overrun |
| 1 | parity error |
| 2 | framing error |
| 3 | received break |
| 4 | FIFO full |
| 5 | receiver ready |
| 6 | transmitter empty |
| 7 | transmitter ready |
| 8 | delta break |

Top module: `uart_cmd_ctrl`

## Requirements
- R1: After reset, `tx_en`, `rx_en`, `brk_active`, all pulse outputs and all nine bits of `flags` are 0.
- R2: A write with bits 6:4 = 001 raises `mode_ptr_rst` for exactly the cycle after the write. A cycle without a write produces no pulse on any pulse output.
- R3: Bits 6:4 = 010 (receiver reset) has four effects and changes nothing else:
  - it clears `rx_en`;
  - it clears flag bit 4 (FIFO full);
  - it clears flag bit 5 (receiver ready);
  - it pulses `rx_fifo_rst`.
- R4: Bits 6:4 = 011 (transmitter reset) clears `tx_en`, flag bit 6 (transmitter empty) and flag bit 7 (transmitter ready), and changes nothing else.
- R5: Bits 6:4 = 100 clears flag bits 3 to 0 (received break, framing, parity and overrun) and no other flag.
- R6: Bits 6:4 = 101 clears flag bit 8 (delta break) and no other flag.
- R7: Break start and stop behave as follows:
  - Bits 6:4 = 110 is accepted only when `tx_en` was 1 before the write. When accepted, it pulses `brk_start` and sets `brk_active`; otherwise it has no effect.
  - Bits 6:4 = 111 pulses `brk_stop` and clears `brk_active`.
- R8: The transmitter field (bits 3:2) and the receiver field (bits 1:0) use the same encoding: 01 enables the path, 10 disables it, and 00 or 11 leaves it unchanged.
- R9: When a path reset and an enable field for the same path come in one write, the reset is applied first and the enable field second, so 01 leaves the path enabled.
- R10: Bit 7 of the command byte has no effect on any output.
- R11: Each bit of `flag_set` sets its flag in the next cycle. A clear and a set of the same flag in one cycle leave the flag at 0. Without a write or a set, the flags and enables hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_wr | input | 1 | Write strobe for the command byte |
| cmd_data | input | 8 | Command byte |
| flag_set | input | 9 | Per-flag set events from the datapath |
| tx_en | output | 1 | Transmitter enable level |
| rx_en | output | 1 | Receiver enable level |
| mode_ptr_rst | output | 1 | Pulse: return mode pointer to first mode register |
| rx_fifo_rst | output | 1 | Pulse: reinitialise receive FIFO pointer |
| brk_start | output | 1 | Pulse: accepted break start |
| brk_stop | output | 1 | Pulse: break stop |
| brk_active | output | 1 | Break request level |
| flags | output | 9 | Status flag state |

## Verification
The assertions check four behaviours on every cycle:

- an enable request lands in the following cycle, and a path reset without an enable leaves the path off;
- enables and flags hold still when nothing acts on them;
- a cleared flag reads 0 after the clear;
- a break-start pulse only follows a cycle with the transmitter enabled.

Other behaviours can only be shown by the bench's scenarios. These are the exact subset of flags each reset command touches, the fact that bit 7 and the reserved field code do nothing, and reset-then-enable ordering in a single write. The bench shows them by comparing every output against a reference model, under random writes mixed with directed command bytes.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;
  localparam int CMD_W   = 8;
  localparam int FLAG_N  = 9;
  localparam int MISC_LO = 4;
  localparam int TXF_LO  = 2;
  localparam int RXF_LO  = 0;

  localparam int F_OVR   = 0;
  localparam int F_PAR   = 1;
  localparam int F_FRM   = 2;
  localparam int F_RBRK  = 3;
  localparam int F_FFULL = 4;
  localparam int F_RXRDY = 5;
  localparam int F_TXEMP = 6;
  localparam int F_TXRDY = 7;
  localparam int F_DBRK  = 8;

  typedef enum logic [2:0] {
    MISC_NOP    = 3'd0,
    MISC_MPTR   = 3'd1,
    MISC_RXRST  = 3'd2,
    MISC_TXRST  = 3'd3,
    MISC_ERRCLR = 3'd4,
    MISC_DBCLR  = 3'd5,
    MISC_BRKON  = 3'd6,
    MISC_BRKOFF = 3'd7
  } misc_e;

  typedef enum logic [1:0] {
    PATH_KEEP = 2'd0,
    PATH_ON   = 2'd1,
    PATH_OFF  = 2'd2,
    PATH_RSV  = 2'd3
  } path_e;

  typedef struct packed {
    logic mptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic err_clr;
    logic db_clr;
    logic brk_on;
    logic brk_off;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_t;
endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_cmd_pkg::*;
#(
  parameter int W = CMD_W
) (
  input  logic         wr,
  input  logic [W-1:0] data,
  output cmd_t         cmd
);
  misc_e misc;
  path_e txf;
  path_e rxf;
  logic  unused_rsv;

  assign misc       = misc_e'(data[MISC_LO +: 3]);
  assign txf        = path_e'(data[TXF_LO +: 2]);
  assign rxf        = path_e'(data[RXF_LO +: 2]);
  assign unused_rsv = data[W-1];

  always_comb begin
    cmd = '0;
    if (wr) begin
      case (misc)
        MISC_MPTR:   cmd.mptr_rst = 1'b1;
        MISC_RXRST:  cmd.rx_rst   = 1'b1;
        MISC_TXRST:  cmd.tx_rst   = 1'b1;
        MISC_ERRCLR: cmd.err_clr  = 1'b1;
        MISC_DBCLR:  cmd.db_clr   = 1'b1;
        MISC_BRKON:  cmd.brk_on   = 1'b1;
        MISC_BRKOFF: cmd.brk_off  = 1'b1;
        default:     ;
      endcase
      cmd.tx_on  = (txf == PATH_ON);
      cmd.tx_off = (txf == PATH_OFF);
      cmd.rx_on  = (rxf == PATH_ON);
      cmd.rx_off = (rxf == PATH_OFF);
    end
  end
endmodule

// File: rtl/uart_cmd_path_en.sv
module uart_cmd_path_en (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req,
  input  logic on_req,
  input  logic off_req,
  output logic en
);
  logic en_q;
  logic en_d;
  logic upd;

  assign upd = rst_req | on_req | off_req;

  always_comb begin
    en_d = en_q;
    if (rst_req) en_d = 1'b0;
    if (on_req)       en_d = 1'b1;
    else if (off_req) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   en_q <= 1'b0;
    else if (upd) en_q <= en_d;
  end

  assign en = en_q;

  // R8
  en_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_req |=> en_q);

  // R9
  rst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !on_req) |=> !en_q);

  // R11
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req || on_req || off_req) |=> $stable(en_q));
endmodule

// File: rtl/uart_cmd_status.sv
module uart_cmd_status #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic nxt;
    logic ce;
    assign ce  = set_i[i] | clr_i[i];
    assign nxt = set_i[i] & ~clr_i[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flags_q[i] <= 1'b0;
      else if (ce) flags_q[i] <= nxt;
    end
  end

  assign flags = flags_q;

  // R11
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((flags_q & $past(clr_i)) == '0));

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(flags_q));
endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
  import uart_cmd_pkg::*;
#(
  parameter int W = CMD_W,
  parameter int N = FLAG_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_wr,
  input  logic [W-1:0] cmd_data,
  input  logic [N-1:0] flag_set,
  output logic         tx_en,
  output logic         rx_en,
  output logic         mode_ptr_rst,
  output logic         rx_fifo_rst,
  output logic         brk_start,
  output logic         brk_stop,
  output logic         brk_active,
  output logic [N-1:0] flags
);
  logic   rst_meta;
  logic   rst_s;
  cmd_t   cmd;
  logic [N-1:0] clr;
  logic   brk_acc;
  logic   brk_d;
  logic   brk_q;
  logic   brk_ce;
  logic [3:0] pls_d;
  logic [3:0] pls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  uart_cmd_decode #(.W(W)) u_dec (
    .wr   (cmd_wr),
    .data (cmd_data),
    .cmd  (cmd)
  );

  uart_cmd_path_en u_tx_en (
    .clk     (clk),
    .rst_n   (rst_s),
    .rst_req (cmd.tx_rst),
    .on_req  (cmd.tx_on),
    .off_req (cmd.tx_off),
    .en      (tx_en)
  );

  uart_cmd_path_en u_rx_en (
    .clk     (clk),
    .rst_n   (rst_s),
    .rst_req (cmd.rx_rst),
    .on_req  (cmd.rx_on),
    .off_req (cmd.rx_off),
    .en      (rx_en)
  );

  always_comb begin
    clr          = '0;
    clr[F_FFULL] = cmd.rx_rst;
    clr[F_RXRDY] = cmd.rx_rst;
    clr[F_TXEMP] = cmd.tx_rst;
    clr[F_TXRDY] = cmd.tx_rst;
    clr[F_OVR]   = cmd.err_clr;
    clr[F_PAR]   = cmd.err_clr;
    clr[F_FRM]   = cmd.err_clr;
    clr[F_RBRK]  = cmd.err_clr;
    clr[F_DBRK]  = cmd.db_clr;
  end

  uart_cmd_status #(.N(N)) u_stat (
    .clk   (clk),
    .rst_n (rst_s),
    .set_i (flag_set),
    .clr_i (clr),
    .flags (flags)
  );

  assign brk_acc = cmd.brk_on & tx_en;
  assign brk_ce  = brk_acc | cmd.brk_off;

  always_comb begin
    brk_d = brk_q;
    if (brk_acc)     brk_d = 1'b1;
    if (cmd.brk_off) brk_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      brk_q <= 1'b0;
    else if (brk_ce) brk_q <= brk_d;
  end

  assign pls_d = {cmd.brk_off, brk_acc, cmd.rx_rst, cmd.mptr_rst};

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) pls_q <= '0;
    else        pls_q <= pls_d;
  end

  assign mode_ptr_rst = pls_q[0];
  assign rx_fifo_rst  = pls_q[1];
  assign brk_start    = pls_q[2];
  assign brk_stop     = pls_q[3];
  assign brk_active   = brk_q;

  // R7
  brk_needs_tx_chk: assert property (@(posedge clk) disable iff (!rst_s)
    brk_start |-> $past(tx_en));

  // R7
  brk_level_chk: assert property (@(posedge clk) disable iff (!rst_s)
    brk_start |-> brk_active);

  // R2
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_ptr_rst || rx_fifo_rst || brk_start || brk_stop) |-> $past(cmd_wr));
endmodule

// File: tb/uart_cmd_ctrl_bench.sv
module uart_cmd_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_data = '0;
  logic [8:0] flag_set = '0;
  logic       tx_en, rx_en, mode_ptr_rst, rx_fifo_rst;
  logic       brk_start, brk_stop, brk_active;
  logic [8:0] flags;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;
  bit done = 1'b0;

  logic       m_tx = 0, m_rx = 0, m_brk = 0;
  logic       m_mptr = 0, m_rxf = 0, m_bs = 0, m_bp = 0;
  logic [8:0] m_flags = '0;

  always #4 clk = ~clk;

  uart_cmd_ctrl u_uart_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .flag_set(flag_set), .tx_en(tx_en), .rx_en(rx_en),
    .mode_ptr_rst(mode_ptr_rst), .rx_fifo_rst(rx_fifo_rst),
    .brk_start(brk_start), .brk_stop(brk_stop), .brk_active(brk_active),
    .flags(flags)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] clr_mask(input logic w, input logic [2:0] misc);
    if (!w) return 9'h000;
    case (misc)
      3'd2:    return 9'h030;
      3'd3:    return 9'h0C0;
      3'd4:    return 9'h00F;
      3'd5:    return 9'h100;
      default: return 9'h000;
    endcase
  endfunction

  task automatic compare_all();
    chk("R4 R8 R9 tx_en", {8'h0, tx_en}, {8'h0, m_tx});
    chk("R3 R8 R9 rx_en", {8'h0, rx_en}, {8'h0, m_rx});
    chk("R2 mode_ptr_rst", {8'h0, mode_ptr_rst}, {8'h0, m_mptr});
    chk("R3 rx_fifo_rst", {8'h0, rx_fifo_rst}, {8'h0, m_rxf});
    chk("R7 brk_start", {8'h0, brk_start}, {8'h0, m_bs});
    chk("R7 brk_stop", {8'h0, brk_stop}, {8'h0, m_bp});
    chk("R7 brk_active", {8'h0, brk_active}, {8'h0, m_brk});
    chk("R5 R6 R11 flags", flags, m_flags);
  endtask

  task automatic cyc(input logic w, input logic [7:0] d, input logic [8:0] s);
    logic [2:0] misc;
    logic       ntx, nrx, nbrk;
    compare_all();
    cmd_wr = w; cmd_data = d; flag_set = s;
    misc = d[6:4];
    ntx = m_tx; nrx = m_rx; nbrk = m_brk;
    m_mptr = w && misc == 3'd1;
    m_rxf  = w && misc == 3'd2;
    m_bs   = w && misc == 3'd6 && m_tx;
    m_bp   = w && misc == 3'd7;
    if (m_rxf) nrx = 1'b0;
    if (w && misc == 3'd3) ntx = 1'b0;
    if (m_bs) nbrk = 1'b1;
    if (m_bp) nbrk = 1'b0;
    if (w) begin
      if (d[3:2] == 2'b01) ntx = 1'b1; else if (d[3:2] == 2'b10) ntx = 1'b0;
      if (d[1:0] == 2'b01) nrx = 1'b1; else if (d[1:0] == 2'b10) nrx = 1'b0;
    end
    m_flags = (m_flags | s) & ~clr_mask(w, misc);
    m_tx = ntx; m_rx = nrx; m_brk = nbrk;
    @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected below 100000", cyc_cnt);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset tx_en", {8'h0, tx_en}, 9'h0);
    chk("R1 reset rx_en", {8'h0, rx_en}, 9'h0);
    chk("R1 reset brk_active", {8'h0, brk_active}, 9'h0);
    chk("R1 reset flags", flags, 9'h0);
    // R2 mode pointer pulse, then idle
    cyc(1, 8'h10, 9'h0);
    cyc(0, 8'h10, 9'h0);
    // R11 set all flags, R5 clear errors, R6 clear delta break
    cyc(0, 8'h00, 9'h1FF);
    cyc(1, 8'h40, 9'h0);
    cyc(1, 8'h50, 9'h0);
    cyc(0, 8'h00, 9'h1FF);
    // R11 clear beats set in the same cycle
    cyc(1, 8'h40, 9'h00F);
    // R7 start break rejected with transmitter off
    cyc(1, 8'h60, 9'h0);
    // R8 enable both, R7 accepted start, stop
    cyc(1, 8'h05, 9'h0);
    cyc(1, 8'h60, 9'h0);
    cyc(1, 8'h70, 9'h0);
    // R8 reserved field code 11 leaves paths alone
    cyc(1, 8'h0F, 9'h0);
    // R9 transmitter reset plus enable; receiver reset plus enable
    cyc(0, 8'h00, 9'h1FF);
    cyc(1, 8'h34, 9'h0);
    cyc(1, 8'h21, 9'h0);
    // R3 R4 plain resets
    cyc(1, 8'h20, 9'h0);
    cyc(1, 8'h30, 9'h0);
    // R10 bit 7 set on enable and on error clear
    cyc(1, 8'h85, 9'h1FF);
    cyc(1, 8'hC0, 9'h0);
    cyc(1, 8'hA0, 9'h0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic       w;
      logic [7:0] d;
      logic [8:0] s;
      w = ($urandom % 10) < 6;
      d = 8'($urandom);
      s = 9'($urandom & $urandom & $urandom);
      cyc(w, d, s);
    end
    cyc(0, 8'h00, 9'h0);
    compare_all();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule